// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out the hardware side of taking an interrupt on a 16-bit segmented processor that runs in real mode. A pending request arrives with an 8-bit vector number. The sequencer first decides whether the request may be taken. This depends on the interrupt-enable bit of the flags word, on the vector number, and on whether a segment-override prefix is still in effect. If the request is taken, the sequencer saves the machine state on the stack, clears the enable and trap bits, and fetches the new code address from the vector table at the bottom of memory.

All memory traffic goes through a single byte-wide request/acknowledge port. Each byte is one handshake. Three words are pushed first: the flags, then the code segment, then the instruction pointer. After that, four bytes are read from the table. When the new code segment has been loaded, the block raises a one-cycle completion strobe. The surrounding core treats that strobe as the command to drop its pending-request flag and its prefix/override state.

Top module: `intEntrySeq`

## Requirements
- R1: A pending request is accepted when flags bit 9 (interrupt enable) is 1, or when the vector is 0 or 2 whatever bit 9 holds; otherwise no memory request is issued while it stays pending.
- R2: While `segOvrPend` is high, no request is accepted. A request held pending through that time is accepted once `segOvrPend` falls.
- R3: Three words are pushed in the order flags, CS, IP. For push k (k = 0, 1, 2), the stack offset is SP − 2(k+1). The low byte is written at that offset and the high byte at the offset plus 1, with offsets wrapping at 16 bits. After entry, `spOut` equals SP − 6.
- R4: The pushed flags word is the flags value at acceptance. After entry, `flagsOut` holds that value with bit 9 and bit 8 (trap) cleared and every other bit kept.
- R5: If `repPrefixPend` or `segOvrPend` is high when the request is accepted, the saved IP is IP − 1 (16-bit wrap). Otherwise the saved IP is IP unchanged.
- R6: After the pushes, four reads go to physical addresses vector·4, vector·4+1, vector·4+2 and vector·4+3, in that order. `ipOut` = {byte1, byte0} and `csOut` = {byte3, byte2}.
- R7: Every stack physical address is (SS·16 + offset) mod 2^20.
- R8: `memReq` stays high, with `memAddr`, `memWe` and `memWdata` stable, until `memAck` is seen at a clock edge. `memRdata` is taken in the acknowledge cycle, and the acknowledge may arrive in the first cycle of the request.
- R9: `doneStb` is high for exactly one cycle, the cycle after the clock edge that accepts the last read. `csOut`, `ipOut`, `spOut` and `flagsOut` are valid in that cycle.
- R10: After reset, `memReq` and `doneStb` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPend | input | 1 | Interrupt request pending |
| irqVec | input | 8 | Vector number of the pending request |
| segOvrPend | input | 1 | Segment-override prefix in effect |
| repPrefixPend | input | 1 | Repeat prefix consumed, instruction not yet finished |
| flagsIn | input | 16 | Current flags word (bit 9 enable, bit 8 trap) |
| csIn | input | 16 | Current code segment |
| ipIn | input | 16 | Current instruction pointer |
| spIn | input | 16 | Current stack pointer |
| ssIn | input | 16 | Current stack segment |
| memReq | output | 1 | Memory byte request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 20 | Physical byte address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid with memAck |
| memAck | input | 1 | Memory accepts the current byte |
| csOut | output | 16 | New code segment |
| ipOut | output | 16 | New instruction pointer |
| spOut | output | 16 | Stack pointer after the pushes |
| flagsOut | output | 16 | Flags after entry |
| doneStb | output | 1 | One-cycle completion; clears pending and prefix state |

## Verification
An accepted request shows `memReq` one cycle after the edge that samples `irqPend`. Each later byte follows one cycle after the acknowledging edge, so the bench's memory model checks the head of its expected-byte queue on the falling edge at which it raises `memAck`, using varying acknowledge delays of 0 to 2 cycles. `doneStb` and the four results are due exactly one cycle after the edge that took the last read acknowledge. The bench records that edge's cycle number and compares the results on the very next falling edge, then checks that the strobe is gone one cycle later. For blocked requests the model holds an empty queue, so any `memReq` on any falling edge is a miscompare.

// File: rtl/intEntryPkg.sv
package intEntryPkg;
  localparam int PUSH_STEPS  = 6;   // three words, two bytes each
  localparam int READ_STEPS  = 4;   // IP word then CS word
  localparam int TOTAL_STEPS = PUSH_STEPS + READ_STEPS;
  localparam int STEP_W      = $clog2(TOTAL_STEPS);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;   // latch inputs at acceptance
    logic              isWrite;   // current step is a stack push byte
    logic              loadByte;  // read byte is being acknowledged
    logic [STEP_W-1:0] step;      // byte step index
  } ctlStrb_t;
endpackage

// File: rtl/intEntryCtl.sv
module intEntryCtl
  import intEntryPkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int BYPASS_A = 0,
  parameter int BYPASS_B = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqPend,
  input  logic [VEC_W-1:0] irqVec,
  input  logic             segOvrPend,
  input  logic             enFlag,
  input  logic             memAck,
  output ctlStrb_t         strb,
  output logic             memReq,
  output logic             doneStb
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_STEPS - 1);
  localparam logic [STEP_W-1:0] FIRST_RD  = STEP_W'(PUSH_STEPS);

  seqState_t         state;
  logic [STEP_W-1:0] stepQ;
  logic              unmaskable;
  logic              accept;

  assign unmaskable = (irqVec == VEC_W'(BYPASS_A)) || (irqVec == VEC_W'(BYPASS_B));
  assign accept     = (state == SEQ_IDLE) && irqPend && !segOvrPend && (enFlag || unmaskable);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      stepQ <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (accept) begin
          state <= SEQ_RUN;
          stepQ <= '0;
        end
        SEQ_RUN: if (memAck) begin
          if (stepQ == LAST_STEP) state <= SEQ_DONE;
          else stepQ <= stepQ + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture  = accept;
    strb.isWrite  = (stepQ < FIRST_RD);
    strb.step     = stepQ;
    strb.loadByte = (state == SEQ_RUN) && memAck && (stepQ >= FIRST_RD);
    memReq        = (state == SEQ_RUN);
    doneStb       = (state == SEQ_DONE);
  end
endmodule

// File: rtl/intEntryPath.sv
module intEntryPath
  import intEntryPkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic              segOvrPend,
  input  logic              repPrefixPend,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic [WORD_W-1:0] ssIn,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] flagsOut
);
  localparam int                FULL_W    = WORD_W + SEG_SHIFT + 1;
  localparam logic [WORD_W-1:0] CLR_MASK  = WORD_W'((1 << IF_BIT) | (1 << TF_BIT));
  localparam logic [WORD_W-1:0] PUSH_SPAN = WORD_W'(PUSH_STEPS);

  logic [WORD_W-1:0] flagsQ, csQ, ipSaveQ, spQ, ssQ, flagsOutQ, spOutQ;
  logic [VEC_W-1:0]  vecQ;
  logic [7:0]        rdByte [READ_STEPS];

  // captured state at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ    <= '0;
      csQ       <= '0;
      ipSaveQ   <= '0;
      spQ       <= '0;
      ssQ       <= '0;
      vecQ      <= '0;
      flagsOutQ <= '0;
      spOutQ    <= '0;
    end else if (strb.capture) begin
      flagsQ    <= flagsIn;
      csQ       <= csIn;
      ipSaveQ   <= ipIn - WORD_W'(segOvrPend | repPrefixPend);
      spQ       <= spIn;
      ssQ       <= ssIn;
      vecQ      <= irqVec;
      flagsOutQ <= flagsIn & ~CLR_MASK;
      spOutQ    <= spIn - PUSH_SPAN;
    end
  end

  // stack address and write byte
  logic [2:0]        wordIdx;
  logic              byteSel;
  logic [WORD_W-1:0] pushOff;
  logic [WORD_W-1:0] wordSel;
  logic [FULL_W-1:0] physSum;
  logic [ADDR_W-1:0] stackAddr;
  logic [ADDR_W-1:0] tblAddr;
  logic [1:0]        rdIdx;

  assign wordIdx = strb.step[3:1];
  assign byteSel = strb.step[0];
  assign pushOff = spQ - {{(WORD_W-4){1'b0}}, wordIdx, 1'b0} - WORD_W'(2) + WORD_W'(byteSel);
  assign physSum = FULL_W'({ssQ, {SEG_SHIFT{1'b0}}}) + FULL_W'(pushOff);
  assign stackAddr = physSum[ADDR_W-1:0];
  assign rdIdx   = 2'(strb.step - STEP_W'(PUSH_STEPS));
  assign tblAddr = ADDR_W'({vecQ, rdIdx});

  always_comb begin
    unique case (wordIdx)
      3'd0:    wordSel = flagsQ;
      3'd1:    wordSel = csQ;
      default: wordSel = ipSaveQ;
    endcase
    memWdata = byteSel ? wordSel[15:8] : wordSel[7:0];
    memAddr  = strb.isWrite ? stackAddr : tblAddr;
  end

  // vector-table byte registers
  for (genvar b = 0; b < READ_STEPS; b++) begin : gRdByte
    always_ff @(posedge clk) begin
      if (!rstN) rdByte[b] <= '0;
      else if (strb.loadByte && (rdIdx == 2'(b))) rdByte[b] <= memRdata;
    end
  end

  assign ipOut    = {rdByte[1], rdByte[0]};
  assign csOut    = {rdByte[3], rdByte[2]};
  assign spOut    = spOutQ;
  assign flagsOut = flagsOutQ;
endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intEntryPkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int BYPASS_A  = 0,
  parameter int BYPASS_B  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqPend,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic              segOvrPend,
  input  logic              repPrefixPend,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic [WORD_W-1:0] ssIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memAck,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] flagsOut,
  output logic              doneStb
);
  ctlStrb_t strb;

  intEntryCtl #(.VEC_W(VEC_W), .BYPASS_A(BYPASS_A), .BYPASS_B(BYPASS_B)) uCtl (
    .clk(clk), .rstN(rstN), .irqPend(irqPend), .irqVec(irqVec),
    .segOvrPend(segOvrPend), .enFlag(flagsIn[IF_BIT]), .memAck(memAck),
    .strb(strb), .memReq(memReq), .doneStb(doneStb)
  );

  intEntryPath #(.VEC_W(VEC_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
                 .SEG_SHIFT(SEG_SHIFT), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .irqVec(irqVec),
    .segOvrPend(segOvrPend), .repPrefixPend(repPrefixPend),
    .flagsIn(flagsIn), .csIn(csIn), .ipIn(ipIn), .spIn(spIn), .ssIn(ssIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .csOut(csOut), .ipOut(ipOut), .spOut(spOut), .flagsOut(flagsOut)
  );

  assign memWe = memReq & strb.isWrite;
endmodule

// File: rtl/intEntryChk.sv
module intEntryChk #(
  parameter int VEC_W    = 8,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 20,
  parameter int IF_BIT   = 9,
  parameter int TF_BIT   = 8,
  parameter int BYPASS_A = 0,
  parameter int BYPASS_B = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqPend,
  input logic [VEC_W-1:0]  irqVec,
  input logic              segOvrPend,
  input logic [WORD_W-1:0] flagsIn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              memAck,
  input logic [WORD_W-1:0] flagsOut,
  input logic              doneStb
);
  AST_MASKED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && irqPend && !flagsIn[IF_BIT] && irqVec != VEC_W'(BYPASS_A) && irqVec != VEC_W'(BYPASS_B))
      |=> !memReq) else $error("masked request started"); // R1

  AST_OVR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && segOvrPend) |=> !memReq) else $error("start under override"); // R2

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!flagsOut[IF_BIT] && !flagsOut[TF_BIT])) else $error("flags not cleared"); // R4

  AST_TABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr[ADDR_W-1:VEC_W+2] == '0)) else $error("table read high"); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)))
    else $error("request dropped or changed"); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb) else $error("done longer than one cycle"); // R9

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneStb) |-> $past(memReq && memAck && !memWe)) else $error("done without final read"); // R9
endmodule

bind intEntrySeq intEntryChk #(
  .VEC_W(VEC_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT),
  .BYPASS_A(BYPASS_A), .BYPASS_B(BYPASS_B)
) uChk (
  .clk(clk), .rstN(rstN), .irqPend(irqPend), .irqVec(irqVec), .segOvrPend(segOvrPend),
  .flagsIn(flagsIn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memAck(memAck), .flagsOut(flagsOut), .doneStb(doneStb)
);

// File: tb/tb_intEntrySeq.sv
module tb_intEntrySeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqPend = 1'b0;
  logic [7:0]  irqVec = '0;
  logic        segOvrPend = 1'b0;
  logic        repPrefixPend = 1'b0;
  logic [15:0] flagsIn = '0, csIn = '0, ipIn = '0, spIn = '0, ssIn = '0;
  logic        memReq, memWe, doneStb;
  logic [19:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        memAck = 1'b0;
  logic [15:0] csOut, ipOut, spOut, flagsOut;

  intEntrySeq dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    bit        we;
    bit [19:0] addr;
    bit [7:0]  data;
  } txn_t;

  txn_t        expQ[$];
  int          nChk = 0, nFail = 0;
  int          cyc = 0, lastAckCyc = -10, txnCount = 0, waitCnt = 0;
  bit          expectDone = 0;
  logic [15:0] expIp, expCs, expSp, expFlags;

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return (a[7:0] * 8'd13) ^ {a[9:8], a[13:10], a[15:14]} ^ 8'hC3;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'b0} + {5'b0, off};
    return s[19:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model: build expected byte traffic and results
  task automatic planEntry(input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                           input logic [15:0] sp, input logic [15:0] ss, input logic [7:0] vec,
                           input bit rewind);
    logic [15:0] words [3];
    words[0] = fl;
    words[1] = cs;
    words[2] = rewind ? ip - 16'd1 : ip;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] off;
      off = sp - 16'(2 * (k + 1));
      expQ.push_back('{1'b1, phys(ss, off), words[k][7:0]});
      expQ.push_back('{1'b1, phys(ss, off + 16'd1), words[k][15:8]});
    end
    for (int r = 0; r < 4; r++) begin
      logic [19:0] a;
      a = {10'd0, vec, 2'(r)};
      expQ.push_back('{1'b0, a, memByte(a)});
    end
    expIp    = {memByte({10'd0, vec, 2'd1}), memByte({10'd0, vec, 2'd0})};
    expCs    = {memByte({10'd0, vec, 2'd3}), memByte({10'd0, vec, 2'd2})};
    expSp    = sp - 16'd6;
    expFlags = fl & 16'hFCFF;
    expectDone = 1;
  endtask

  // memory model and per-cycle compare
  always @(negedge clk) begin
    cyc++;
    memAck = 1'b0;
    if (rstN && memReq) begin
      if (waitCnt == 0) begin
        if (expQ.size() == 0) begin
          check("R1/R2 unexpected request", {11'd0, memWe, memAddr}, 32'h0);
        end else begin
          txn_t e;
          e = expQ.pop_front();
          check("R3/R6/R7 direction", {31'd0, memWe}, {31'd0, e.we});
          check("R3/R6/R7 address", {12'd0, memAddr}, {12'd0, e.addr});
          if (e.we) check("R3/R4/R5 write byte", {24'd0, memWdata}, {24'd0, e.data});
        end
        memAck   = 1'b1;
        memRdata = memByte(memAddr);
        lastAckCyc = cyc;
        txnCount++;
        waitCnt = txnCount % 3;
      end else begin
        waitCnt--;
      end
    end
    if (rstN && doneStb && !expectDone) check("R9 spurious done", 32'd1, 32'd0);
  end

  task automatic waitDone(input string tag);
    int n;
    n = 0;
    while (!doneStb && n < 200) begin
      @(negedge clk); #1;
      n++;
    end
    check({tag, " R9 done seen"}, {31'd0, doneStb}, 32'd1);
    check({tag, " R9 done one cycle after last ack"}, cyc, lastAckCyc + 1);
    check({tag, " R6 ipOut"}, {16'd0, ipOut}, {16'd0, expIp});
    check({tag, " R6 csOut"}, {16'd0, csOut}, {16'd0, expCs});
    check({tag, " R3 spOut"}, {16'd0, spOut}, {16'd0, expSp});
    check({tag, " R4 flagsOut"}, {16'd0, flagsOut}, {16'd0, expFlags});
    check({tag, " R3 all bytes issued"}, expQ.size(), 0);
    irqPend = 1'b0;
    repPrefixPend = 1'b0;
    expectDone = 0;
    @(negedge clk); #1;
    check({tag, " R9 done dropped"}, {31'd0, doneStb}, 32'd0);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic raise(input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                       input logic [15:0] sp, input logic [15:0] ss, input logic [7:0] vec);
    flagsIn = fl; csIn = cs; ipIn = ip; spIn = sp; ssIn = ss; irqVec = vec;
    irqPend = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 memReq after reset", {31'd0, memReq}, 32'd0);
    check("R10 doneStb after reset", {31'd0, doneStb}, 32'd0);
    check("R10 outputs after reset", {csOut, ipOut}, 32'd0);
    check("R10 sp/flags after reset", {spOut, flagsOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #1;

    // enabled, ordinary vector (R1)
    planEntry(16'h0200, 16'h1234, 16'h5678, 16'h0100, 16'h2000, 8'h21, 0);
    raise(16'h0200, 16'h1234, 16'h5678, 16'h0100, 16'h2000, 8'h21);
    waitDone("R1 enabled");

    // disabled, vector 0 bypasses, trap bit cleared (R1 R4)
    planEntry(16'h0D55, 16'hABCD, 16'h0010, 16'hFFF0, 16'h0030, 8'h00, 0);
    raise(16'h0D55, 16'hABCD, 16'h0010, 16'hFFF0, 16'h0030, 8'h00);
    waitDone("R1 vector0");

    // disabled, vector 2 bypasses (R1)
    planEntry(16'h0000, 16'h0F00, 16'h8000, 16'h4000, 16'h1111, 8'h02, 0);
    raise(16'h0000, 16'h0F00, 16'h8000, 16'h4000, 16'h1111, 8'h02);
    waitDone("R1 vector2");

    // disabled, maskable vector stays blocked (R1)
    raise(16'h0000, 16'h0F00, 16'h8000, 16'h4000, 16'h1111, 8'h21);
    repeat (20) begin
      @(negedge clk); #1;
    end
    check("R1 masked request not taken", {31'd0, memReq}, 32'd0);
    irqPend = 1'b0;
    repeat (2) @(negedge clk);
    #1;

    // override holds off, then repeat prefix rewinds IP through zero (R2 R5)
    segOvrPend = 1'b1;
    repPrefixPend = 1'b1;
    planEntry(16'h0300, 16'h7777, 16'h0000, 16'h0200, 16'h0500, 8'h10, 1);
    raise(16'h0300, 16'h7777, 16'h0000, 16'h0200, 16'h0500, 8'h10);
    repeat (15) begin
      @(negedge clk); #1;
    end
    check("R2 held while override", {31'd0, memReq}, 32'd0);
    segOvrPend = 1'b0;
    waitDone("R2 R5 after override");

    // stack offset and physical wrap, top vector (R3 R6 R7)
    planEntry(16'hFFFF, 16'h00FF, 16'h1001, 16'h0001, 16'hFFFF, 8'hFF, 0);
    raise(16'hFFFF, 16'h00FF, 16'h1001, 16'h0001, 16'hFFFF, 8'hFF);
    waitDone("R7 wrap");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule